// File: doc/BRIEF.md
# Grouped Eight-Level Interrupt Prioritizer

This block turns eight level-interrupt sources into a single winning level. Each source pulse latches into a pending bit, and the pending bit stays set until the winning level is acknowledged. A level takes part in arbitration only when three conditions hold: its pending bit is set, its enable bit in the mask register is set, and the global enable in the mode register is on.

Arbitration is a tree with a programmable order at each node. The levels form three groups: A holds levels 0 and 1, B holds levels 2, 3 and 4, and C holds levels 5, 6 and 7. Inside each group, priority bits set the order of the members. Three further priority bits set which group outranks which. One selected level can also be made "fast". When that level is eligible, it wins regardless of the tree, and a service flag records that a fast interrupt is in progress until the flag is released.

Software reaches four registers through a small register port with combinational read data. A CPU-side sequencer drives the acknowledge pulse and the fast-return pulse.

Top module: `irq_group_prio`

## Requirements
- R1: After reset, the pending, mask, mode and priority registers all read 0. `irq_out`, `irq_level`, `fast_hit` and `fast_svc` are all 0.
- R2: A 1 on `irq_req[i]` at a clock edge sets pending bit i. The bit is visible at register address 0 from that edge on and stays set until acknowledged. Writes to address 0 change nothing.
- R3: Mode bit 0 is the global enable. Level i is eligible when pending bit i, mask bit i (address 1) and the global enable are all 1. `irq_out` is 1 exactly when some level is eligible, and `irq_level` then names an eligible level. When no level is eligible, `irq_level` is 0.
- R4: Group A uses priority bit 0. When it is 0, level 0 beats level 1. When it is 1, level 1 beats level 0.
- R5: Group B uses priority bits 2 and 3. When bit 2 is 0, level 2 beats the pair {3,4}. When bit 2 is 1, the pair beats level 2. Inside the pair, bit 3 = 0 favours level 3 and bit 3 = 1 favours level 4.
- R6: Group C works the same way with bits 5 and 6. When bit 5 is 0, level 5 beats the pair {6,7}. Inside the pair, bit 6 = 0 favours level 6 and bit 6 = 1 favours level 7.
- R7: Priority bits {7,4,1} set the group order, listed here from highest to lowest. Code 001 gives B,C,A. Code 010 gives A,B,C. Code 011 gives B,A,C. Code 100 gives C,A,B. Code 101 gives C,B,A. Code 110 gives A,C,B.
- R8: Group-order codes 000 and 111 behave like code 101 (C over B over A).
- R9: Mode bit 1 enables the fast path, and mode bits 4:2 name the fast level. When the fast path is enabled and the fast level is eligible, that level wins and `fast_hit` is 1. In every other case `fast_hit` is 0 and the tree decides.
- R10: `irq_ack` with `irq_out` = 1 clears the pending bit of `irq_level` at that edge. If `irq_req` sets the same bit in the same cycle, the bit stays set. When `irq_out` = 0, `irq_ack` does nothing.
- R11: `fast_svc` becomes 1 after an acknowledge taken while `fast_hit` = 1. `fast_ret` clears it. If both happen in the same cycle, the set wins.
- R12: Addresses 1 and 3 read back the mask and priority bytes as written. Address 2 reads back mode bits 4:0, and mode bits 7:5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 pending, 1 mask, 2 mode, 3 priority |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational on cfg_addr |
| irq_req | input | 8 | Per-level request pulses |
| irq_ack | input | 1 | Acknowledge of the current winner |
| fast_ret | input | 1 | Return from fast service, clears fast_svc |
| irq_out | output | 1 | Some level is eligible |
| irq_level | output | 3 | Winning level |
| fast_hit | output | 1 | The winner came through the fast path |
| fast_svc | output | 1 | A fast interrupt is being serviced |

## Verification
The bench walks every group-order code against requests that sit in two or three groups at once. A mapping with any two groups swapped, or with the unlisted codes left undefined, would therefore name the wrong level. It drives each within-group bit in both directions, including pair-only requests, to catch a subgroup selector that does not fall through when only one side is pending. It also checks three fast-path cases: a fast level that is masked, one that is not pending, and one whose fast enable is off. A design that keyed the override off the raw request would report a fast winner in those cases. Finally, it acknowledges while the same level is re-requested, which exposes a clear that beats a new set.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int unsigned NUM_LVL = 8;
   localparam int unsigned LVL_W   = $clog2(NUM_LVL);
   localparam int unsigned REG_W   = 8;
   localparam int unsigned ADR_W   = 2;

   typedef logic [LVL_W-1:0] lvl_t;

   localparam logic [ADR_W-1:0] ADR_PEND = 2'd0;
   localparam logic [ADR_W-1:0] ADR_MASK = 2'd1;
   localparam logic [ADR_W-1:0] ADR_MODE = 2'd2;
   localparam logic [ADR_W-1:0] ADR_PRIO = 2'd3;

   typedef struct packed {
      lvl_t fast_lvl;
      logic fast_en;
      logic glb_en;
   } mode_t;

   localparam int unsigned MODE_W = $bits(mode_t);

   typedef enum logic [1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_C = 2'd2} grp_e;

   typedef struct packed {
      logic any;
      lvl_t lvl;
   } cand_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_prio_pkg::*;
#(
   parameter int unsigned DW = REG_W,
   parameter int unsigned AW = ADR_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] pend,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] mask,
   output mode_t         mode,
   output logic [DW-1:0] prio
);

   localparam int unsigned PAD_W = DW - MODE_W;

   generate
      if (DW != REG_W) begin : g_bad_dw
         $error("irq_cfg_regs: DW must equal REG_W");
      end
      if (AW != ADR_W) begin : g_bad_aw
         $error("irq_cfg_regs: AW must equal ADR_W");
      end
   endgenerate

   logic wr_mask, wr_mode, wr_prio;

   assign wr_mask = we && (addr == ADR_MASK);
   assign wr_mode = we && (addr == ADR_MODE);
   assign wr_prio = we && (addr == ADR_PRIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
         mode <= '0;
         prio <= '0;
      end else begin
         if (wr_mask) mask <= wdata;
         if (wr_mode) mode <= mode_t'(wdata[MODE_W-1:0]);
         if (wr_prio) prio <= wdata;
      end
   end

   always_comb begin
      unique case (addr)
         ADR_PEND: rdata = pend;
         ADR_MASK: rdata = mask;
         ADR_MODE: rdata = {{PAD_W{1'b0}}, mode};
         default:  rdata = prio;
      endcase
   end

   AST_MODE_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADR_MODE) |-> (rdata[DW-1:MODE_W] == '0)); // R12

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask == $past(wdata))); // R12

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int unsigned NL = irq_prio_pkg::NUM_LVL
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] set_i,
   input  logic [NL-1:0] clr_i,
   output logic [NL-1:0] pend_o
);

   generate
      if (NL < 1) begin : g_bad_nl
         $error("irq_pend_reg: NL must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < NL; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_o[i] <= 1'b0;
         else if (set_i[i]) pend_o[i] <= 1'b1;
         else if (clr_i[i]) pend_o[i] <= 1'b0;
      end

      AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> pend_o[i]); // R10

      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !pend_o[i]); // R10

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !clr_i[i]) |=> $stable(pend_o[i])); // R2
   end

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
   import irq_prio_pkg::*;
#(
   parameter int unsigned NL = NUM_LVL,
   parameter int unsigned PW = REG_W
) (
   input  logic [NL-1:0] elig,
   input  logic [PW-1:0] prio,
   input  mode_t         mode,
   output logic          any,
   output lvl_t          win,
   output logic          fast_hit
);

   generate
      if (NL != 8) begin : g_bad_nl
         $error("irq_pick_tree: the group tree is built for eight levels");
      end
      if (PW != 8) begin : g_bad_pw
         $error("irq_pick_tree: priority register must be eight bits");
      end
   endgenerate

   // a pair: 'second' is preferred when sel is set
   function automatic cand_t pick2(input cand_t first, input cand_t second, input logic sel);
      cand_t r;
      r.any = first.any | second.any;
      if (sel) r.lvl = second.any ? second.lvl : first.lvl;
      else     r.lvl = first.any  ? first.lvl  : second.lvl;
      return r;
   endfunction

   function automatic cand_t leaf(input logic e, input int unsigned n);
      cand_t r;
      r.any = e;
      r.lvl = lvl_t'(n);
      return r;
   endfunction

   cand_t c_a, c_b, c_c, c_b_pair, c_c_pair, c_tree;
   grp_e  ord [3];

   assign c_a      = pick2(leaf(elig[0], 0), leaf(elig[1], 1), prio[0]);
   assign c_b_pair = pick2(leaf(elig[3], 3), leaf(elig[4], 4), prio[3]);
   assign c_b      = pick2(leaf(elig[2], 2), c_b_pair, prio[2]);
   assign c_c_pair = pick2(leaf(elig[6], 6), leaf(elig[7], 7), prio[6]);
   assign c_c      = pick2(leaf(elig[5], 5), c_c_pair, prio[5]);

   // group order, highest first
   always_comb begin
      unique case ({prio[7], prio[4], prio[1]})
         3'b001:  begin ord[0] = GRP_B; ord[1] = GRP_C; ord[2] = GRP_A; end
         3'b010:  begin ord[0] = GRP_A; ord[1] = GRP_B; ord[2] = GRP_C; end
         3'b011:  begin ord[0] = GRP_B; ord[1] = GRP_A; ord[2] = GRP_C; end
         3'b100:  begin ord[0] = GRP_C; ord[1] = GRP_A; ord[2] = GRP_B; end
         3'b110:  begin ord[0] = GRP_A; ord[1] = GRP_C; ord[2] = GRP_B; end
         default: begin ord[0] = GRP_C; ord[1] = GRP_B; ord[2] = GRP_A; end
      endcase
   end

   function automatic cand_t grp_cand(input grp_e g, input cand_t a, input cand_t b, input cand_t c);
      unique case (g)
         GRP_A:   return a;
         GRP_B:   return b;
         default: return c;
      endcase
   endfunction

   always_comb begin
      c_tree = '0;
      for (int k = 2; k >= 0; k--) begin
         if (grp_cand(ord[k], c_a, c_b, c_c).any)
            c_tree = grp_cand(ord[k], c_a, c_b, c_c);
      end
   end

   assign fast_hit = mode.fast_en && elig[mode.fast_lvl];
   assign any      = |elig;
   assign win      = fast_hit ? mode.fast_lvl : (any ? c_tree.lvl : '0);

endmodule

// File: rtl/irq_group_prio.sv
module irq_group_prio
   import irq_prio_pkg::*;
#(
   parameter int unsigned LEVELS = NUM_LVL,
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned ADDR_W = ADR_W,
   localparam int unsigned LW    = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [LEVELS-1:0] irq_req,
   input  logic              irq_ack,
   input  logic              fast_ret,
   output logic              irq_out,
   output logic [LW-1:0]     irq_level,
   output logic              fast_hit,
   output logic              fast_svc
);

   generate
      if (LEVELS != DATA_W) begin : g_bad_width
         $error("irq_group_prio: one register bit per level is required");
      end
      if (LW != LVL_W) begin : g_bad_lw
         $error("irq_group_prio: level width mismatch");
      end
   endgenerate

   logic [LEVELS-1:0] pend, clr, elig;
   logic [DATA_W-1:0] mask, prio;
   mode_t             mode;

   irq_cfg_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .pend  (pend),
      .rdata (cfg_rdata),
      .mask  (mask),
      .mode  (mode),
      .prio  (prio)
   );

   irq_pend_reg #(.NL(LEVELS)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_req),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign elig = pend & mask & {LEVELS{mode.glb_en}};

   irq_pick_tree #(.NL(LEVELS), .PW(DATA_W)) u_tree (
      .elig     (elig),
      .prio     (prio),
      .mode     (mode),
      .any      (irq_out),
      .win      (irq_level),
      .fast_hit (fast_hit)
   );

   for (genvar i = 0; i < LEVELS; i++) begin : g_clr
      assign clr[i] = irq_ack && irq_out && (irq_level == LW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   fast_svc <= 1'b0;
      else if (irq_ack && fast_hit) fast_svc <= 1'b1;
      else if (fast_ret)            fast_svc <= 1'b0;
   end

   AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.glb_en |-> !irq_out); // R3

   AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (pend[irq_level] && mask[irq_level])); // R3

   AST_FAST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      fast_hit |-> (irq_out && irq_level == mode.fast_lvl)); // R9

   AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr)); // R10

   AST_FAST_SVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && fast_hit) |=> fast_svc); // R11

   AST_FAST_SVC_RET: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_ret && !(irq_ack && fast_hit)) |=> !fast_svc); // R11

endmodule

// File: tb/irq_group_prio_bench.sv
module irq_group_prio_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [7:0] irq_req = '0;
   logic       irq_ack = 1'b0;
   logic       fast_ret = 1'b0;
   logic       irq_out;
   logic [2:0] irq_level;
   logic       fast_hit;
   logic       fast_svc;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   irq_group_prio u_irq_group_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .irq_req   (irq_req),
      .irq_ack   (irq_ack),
      .fast_ret  (fast_ret),
      .irq_out   (irq_out),
      .irq_level (irq_level),
      .fast_hit  (fast_hit),
      .fast_svc  (fast_svc)
   );

   // mask, mode, prio, req, exp irq, exp level, exp fast
   localparam int NV = 26;
   localparam logic [43:0] VEC [NV] = '{
      44'hFF_01_00_03_1_0_0, 44'hFF_01_01_03_1_1_0,
      44'hFF_01_00_1C_1_2_0, 44'hFF_01_04_1C_1_3_0, 44'hFF_01_0C_1C_1_4_0,
      44'hFF_01_08_18_1_4_0, 44'hFF_01_00_18_1_3_0,
      44'hFF_01_00_E0_1_5_0, 44'hFF_01_20_E0_1_6_0, 44'hFF_01_60_E0_1_7_0,
      44'hFF_01_00_25_1_5_0, 44'hFF_01_02_25_1_2_0, 44'hFF_01_10_25_1_0_0,
      44'hFF_01_12_25_1_2_0, 44'hFF_01_80_25_1_5_0, 44'hFF_01_82_25_1_5_0,
      44'hFF_01_90_25_1_0_0, 44'hFF_01_92_25_1_5_0,
      44'hFF_01_80_05_1_0_0, 44'hFF_01_90_24_1_5_0,
      44'h0F_01_00_FF_1_2_0, 44'hFF_00_00_FF_0_0_0,
      44'hFF_1B_10_41_1_6_1, 44'hFF_1B_10_01_1_0_0,
      44'hBF_1B_10_41_1_0_0, 44'hFF_19_10_41_1_0_0
   };

   function automatic string tag_of(input int i);
      if (i < 2)  return "R4";
      if (i < 7)  return "R5";
      if (i < 10) return "R6";
      if (i == 10 || i == 17) return "R8";
      if (i < 20) return "R7";
      if (i < 22) return "R3";
      return "R9";
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq_req = '0; irq_ack = 1'b0; fast_ret = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_req(input logic [7:0] r);
      @(negedge clk);
      irq_req = r;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   initial begin : main
      logic [7:0] v;
      do_reset();
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1", "reg after reset", int'(v), 0);
      end
      chk("R1", "irq_out", int'(irq_out), 0);
      chk("R1", "irq_level", int'(irq_level), 0);
      chk("R1", "fast_hit", int'(fast_hit), 0);
      chk("R1", "fast_svc", int'(fast_svc), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         do_reset();
         wr(2'd1, VEC[i][43:36]);
         wr(2'd2, VEC[i][35:28]);
         wr(2'd3, VEC[i][27:20]);
         pulse_req(VEC[i][19:12]);
         #1;
         chk(tag_of(i), $sformatf("vec%0d irq_out", i), int'(irq_out), int'(VEC[i][8]));
         chk(tag_of(i), $sformatf("vec%0d level", i), int'(irq_level), int'(VEC[i][6:4]));
         chk(tag_of(i), $sformatf("vec%0d fast", i), int'(fast_hit), int'(VEC[i][0]));
      end

      // R12 readback and R2 write to pending ignored
      do_reset();
      wr(2'd1, 8'hA5);
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'h5A);
      wr(2'd0, 8'hFF);
      rd(2'd1, v); chk("R12", "mask readback", int'(v), 'hA5);
      rd(2'd2, v); chk("R12", "mode readback", int'(v), 'h1F);
      rd(2'd3, v); chk("R12", "prio readback", int'(v), 'h5A);
      rd(2'd0, v); chk("R2", "pending after write", int'(v), 0);

      // R2 pending held while masked, shows later
      do_reset();
      wr(2'd2, 8'h01);
      pulse_req(8'h10);
      repeat (3) @(negedge clk);
      rd(2'd0, v); chk("R2", "pending held", int'(v), 'h10);
      chk("R2", "masked irq_out", int'(irq_out), 0);
      wr(2'd1, 8'h10);
      #1 chk("R2", "unmasked level", int'(irq_level), 4);

      // R10 acknowledge
      do_reset();
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h01);
      pulse_req(8'h03);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      rd(2'd0, v); chk("R10", "ack clears winner", int'(v), 'h02);
      chk("R10", "next winner", int'(irq_level), 1);
      @(negedge clk); irq_ack = 1'b1; irq_req = 8'h02;
      @(negedge clk); irq_ack = 1'b0; irq_req = '0;
      rd(2'd0, v); chk("R10", "set beats clear", int'(v), 'h02);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      rd(2'd0, v); chk("R10", "last cleared", int'(v), 0);
      chk("R10", "irq_out drops", int'(irq_out), 0);
      wr(2'd1, 8'h00);
      pulse_req(8'h08);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      rd(2'd0, v); chk("R10", "ack with no winner", int'(v), 'h08);

      // R11 fast service flag
      do_reset();
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h1B);
      pulse_req(8'h40);
      #1 chk("R11", "fast_hit before ack", int'(fast_hit), 1);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      #1 chk("R11", "fast_svc set", int'(fast_svc), 1);
      pulse_req(8'h40);
      @(negedge clk); irq_ack = 1'b1; fast_ret = 1'b1;
      @(negedge clk); irq_ack = 1'b0; fast_ret = 1'b0;
      #1 chk("R11", "set beats return", int'(fast_svc), 1);
      @(negedge clk); fast_ret = 1'b1;
      @(negedge clk); fast_ret = 1'b0;
      #1 chk("R11", "fast_svc cleared", int'(fast_svc), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule